// File: doc/BRIEF.md
# Byte-Addressed Serial RAM Target

This block is a synchronous two-wire bus target that gives a bus controller access to an internal byte-wide memory (256 locations by default). A fast system clock oversamples the clock and data lines. Each line passes through a synchroniser and a stability filter before START, STOP and clock edges are detected. The block answers a 7-bit device address made of a fixed four-bit prefix and three strap inputs. The data line is driven open-drain: the block only pulls it low, and the board or bench supplies the pull-up.

A write transfer carries the device byte, then one byte that loads a shared location pointer, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then steps by one. A read either follows a repeated START after a pointer-load write, or starts directly after START. In both cases it streams bytes from the current pointer, which steps after every byte sent. A sleep input holds the bus logic in reset and leaves the stored data untouched.

Top module: `i2c_ram_target`

## Requirements
- R1: After reset, and with idle bus lines, `sda_oe_o` is 0.
- R2: The block acknowledges a device byte only when its upper seven bits equal 1010 followed by `strap_i[2:0]` (MSB first). Bit 0 selects read (1) or write (0). On a mismatch the block returns no acknowledge and ignores later bytes until the next START.
- R3: In a write transfer, the first byte after the device byte loads the pointer, and every later byte is stored at the pointer. The block acknowledges each of these bytes by pulling the data line low during the ninth clock.
- R4: The pointer steps by one after every byte stored or sent, and wraps from its maximum value to 0.
- R5: A repeated START followed by a read device byte returns data starting at the pointer value that was just loaded.
- R6: A read that begins directly after START returns data from the current pointer, with no pointer byte.
- R7: During a read, the bit sent on the ninth clock decides what follows. A low bit (acknowledge) makes the block send the next byte. A high bit (no acknowledge) makes it release the data line and stay silent.
- R8: A STOP ends any transfer. Bytes clocked after a STOP and before the next START get no acknowledge and store nothing.
- R9: While `sleep_i` is 1, the bus logic is held in reset, nothing is acknowledged and the pointer returns to 0. Stored data survives.
- R10: `sda_oe_o` changes only while the filtered clock line is low.
- R11: A one-cycle pulse on either line is rejected by the filter, so it neither corrupts a bit nor creates a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Holds bus logic in reset while 1 |
| strap_i | input | 3 | Low three bits of the device address |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
The embedded assertions check the following on every cycle:
- the data-line driver moves only while the filtered clock is low;
- the driver is enabled only in the acknowledge-out and send phases;
- STOP and sleep return the engine to idle with the line released;
- START always begins a fresh device byte;
- each stored byte is followed by a pointer step;
- the filter output changes only after its input has held steady.

Only the bench scenarios can show the following, because they depend on whole transfers and on values held in memory:
- the data paths end to end: pointer loading, repeated-START and direct reads, and wrap at the top of memory;
- the address-mismatch and post-STOP silence;
- that data survives a sleep period.

// File: rtl/i2cram_pkg.sv
package i2cram_pkg;
   localparam int BYTE_W = 8;
   localparam int STRAP_W = 3;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RECV,
      PH_ACKOUT,
      PH_SEND,
      PH_ACKIN
   } phase_e;

   typedef enum logic [1:0] {
      BK_DEV,
      BK_PTR,
      BK_DATA
   } kind_e;
endpackage

// File: rtl/i2cram_line_filter.sv
module i2cram_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   output logic line_o
);
   localparam int CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   s_in;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 0) begin : g_bad_filt
      $error("FILT_LEN must not be negative");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '1;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end
   assign s_in = sync_q[SYNC_STAGES-1];

   if (FILT_LEN == 0) begin : g_bypass
      assign line_o = s_in;
   end else begin : g_stable
      logic             held_q;
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            held_q <= 1'b1;
            cnt_q  <= '0;
         end else if (s_in == held_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
            held_q <= s_in;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
      assign line_o = held_q;

      if (FILT_LEN >= 2) begin : g_chk
         // R11
         filt_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (held_q != $past(held_q)) |-> ($past(s_in) == held_q && $past(s_in, 2) == held_q));
      end
   end
endmodule

// File: rtl/i2cram_edge_detect.sv
module i2cram_edge_detect (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
   assign scl_rise_o = scl_i & ~scl_q;
   assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2cram_store.sv
module i2cram_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] wa_i,
   input  logic [DATA_W-1:0] wd_i,
   input  logic [ADDR_W-1:0] ra_i,
   output logic [DATA_W-1:0] rd_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) mem_q[wa_i] <= wd_i;
   end

   assign rd_o = mem_q[ra_i];
endmodule

// File: rtl/i2cram_engine.sv
module i2cram_engine
   import i2cram_pkg::*;
#(
   parameter int         ADDR_W     = 8,
   parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               sleep_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               scl_lvl_i,
   input  logic               sda_lvl_i,
   input  logic               scl_rise_i,
   input  logic               scl_fall_i,
   input  logic               start_i,
   input  logic               stop_i,
   output logic [ADDR_W-1:0]  rd_addr_o,
   input  logic [BYTE_W-1:0]  rd_data_i,
   output logic               we_o,
   output logic [ADDR_W-1:0]  wa_o,
   output logic [BYTE_W-1:0]  wd_o,
   output logic               sda_oe_o
);
   phase_e             phase_q;
   kind_e              kind_q;
   logic               rw_q;
   logic               nack_q;
   logic [3:0]         bits_q;
   logic [BYTE_W-1:0]  shreg_q;
   logic [ADDR_W-1:0]  ptr_q;
   logic               oe_q;
   logic               we_q;
   logic [ADDR_W-1:0]  wa_q;
   logic [BYTE_W-1:0]  wd_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         kind_q  <= BK_DEV;
         rw_q    <= 1'b0;
         nack_q  <= 1'b0;
         bits_q  <= '0;
         shreg_q <= '0;
         ptr_q   <= '0;
         oe_q    <= 1'b0;
         we_q    <= 1'b0;
         wa_q    <= '0;
         wd_q    <= '0;
      end else begin
         we_q <= 1'b0;
         if (sleep_i) begin
            phase_q <= PH_IDLE;
            kind_q  <= BK_DEV;
            rw_q    <= 1'b0;
            nack_q  <= 1'b0;
            bits_q  <= '0;
            ptr_q   <= '0;
            oe_q    <= 1'b0;
         end else if (stop_i) begin
            phase_q <= PH_IDLE;
            oe_q    <= 1'b0;
         end else if (start_i) begin
            phase_q <= PH_RECV;
            kind_q  <= BK_DEV;
            bits_q  <= '0;
            oe_q    <= 1'b0;
         end else begin
            unique case (phase_q)
               PH_RECV: begin
                  if (scl_rise_i && bits_q != 4'd8) begin
                     shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
                     bits_q  <= bits_q + 1'b1;
                  end else if (scl_fall_i && bits_q == 4'd8) begin
                     unique case (kind_q)
                        BK_DEV: begin
                           if (shreg_q[7:1] == {DEV_PREFIX, strap_i}) begin
                              rw_q    <= shreg_q[0];
                              oe_q    <= 1'b1;
                              phase_q <= PH_ACKOUT;
                           end else begin
                              phase_q <= PH_IDLE;
                           end
                        end
                        BK_PTR: begin
                           ptr_q   <= shreg_q[ADDR_W-1:0];
                           oe_q    <= 1'b1;
                           phase_q <= PH_ACKOUT;
                        end
                        default: begin
                           we_q    <= 1'b1;
                           wa_q    <= ptr_q;
                           wd_q    <= shreg_q;
                           ptr_q   <= ptr_q + 1'b1;
                           oe_q    <= 1'b1;
                           phase_q <= PH_ACKOUT;
                        end
                     endcase
                  end
               end
               PH_ACKOUT: begin
                  if (scl_fall_i) begin
                     bits_q <= '0;
                     if (rw_q) begin
                        shreg_q <= rd_data_i;
                        ptr_q   <= ptr_q + 1'b1;
                        oe_q    <= ~rd_data_i[BYTE_W-1];
                        phase_q <= PH_SEND;
                     end else begin
                        oe_q    <= 1'b0;
                        phase_q <= PH_RECV;
                        kind_q  <= (kind_q == BK_DEV) ? BK_PTR : BK_DATA;
                     end
                  end
               end
               PH_SEND: begin
                  if (scl_fall_i) begin
                     if (bits_q == 4'd7) begin
                        oe_q    <= 1'b0;
                        phase_q <= PH_ACKIN;
                     end else begin
                        shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                        oe_q    <= ~shreg_q[BYTE_W-2];
                        bits_q  <= bits_q + 1'b1;
                     end
                  end
               end
               PH_ACKIN: begin
                  if (scl_rise_i) begin
                     nack_q <= sda_lvl_i;
                  end else if (scl_fall_i) begin
                     if (nack_q) begin
                        phase_q <= PH_IDLE;
                     end else begin
                        shreg_q <= rd_data_i;
                        ptr_q   <= ptr_q + 1'b1;
                        oe_q    <= ~rd_data_i[BYTE_W-1];
                        bits_q  <= '0;
                        phase_q <= PH_SEND;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_addr_o = ptr_q;
   assign we_o      = we_q;
   assign wa_o      = wa_q;
   assign wd_o      = wd_q;
   assign sda_oe_o  = oe_q;

   // R10
   oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((oe_q != $past(oe_q)) && !$past(sleep_i) && !$past(stop_i) && !$past(start_i)) |-> !scl_lvl_i);

   // R9
   sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_i |=> (!oe_q && phase_q == PH_IDLE));

   // R7
   oe_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_q |-> (phase_q == PH_ACKOUT || phase_q == PH_SEND));

   // R8
   stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_i && !sleep_i) |=> (phase_q == PH_IDLE && !oe_q));

   // R2
   start_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !sleep_i) |=> (phase_q == PH_RECV && kind_q == BK_DEV && bits_q == 4'd0));

   // R4
   ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_q |-> (ptr_q == wa_q + 1'b1));
endmodule

// File: rtl/i2c_ram_target.sv
module i2c_ram_target
   import i2cram_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3,
   parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               sleep_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe_o
);
   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr
      $error("ADDR_W must lie between 1 and the byte width");
   end

   logic scl_f, sda_f;
   logic start_w, stop_w, rise_w, fall_w;
   logic [ADDR_W-1:0] ra_w, wa_w;
   logic [BYTE_W-1:0] rd_w, wd_w;
   logic              we_w;

   i2cram_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) scl_filt_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .line_o(scl_f));

   i2cram_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) sda_filt_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .line_o(sda_f));

   i2cram_edge_detect edge_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
      .start_o(start_w), .stop_o(stop_w), .scl_rise_o(rise_w), .scl_fall_o(fall_w));

   i2cram_engine #(.ADDR_W(ADDR_W), .DEV_PREFIX(DEV_PREFIX)) engine_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .strap_i(strap_i),
      .scl_lvl_i(scl_f), .sda_lvl_i(sda_f), .scl_rise_i(rise_w), .scl_fall_i(fall_w),
      .start_i(start_w), .stop_i(stop_w), .rd_addr_o(ra_w), .rd_data_i(rd_w),
      .we_o(we_w), .wa_o(wa_w), .wd_o(wd_w), .sda_oe_o(sda_oe_o));

   i2cram_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) store_i (
      .clk_i(clk_i), .we_i(we_w), .wa_i(wa_w), .wd_i(wd_w), .ra_i(ra_w), .rd_o(rd_w));
endmodule

// File: tb/i2c_ram_target_tb.sv
`timescale 1ns/1ps
module i2c_ram_target_tb_top;
   localparam int Q = 16;
   localparam logic [7:0] DEV_W = 8'hAA;
   localparam logic [7:0] DEV_R = 8'hAB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep = 1'b0;
   logic [2:0] strap = 3'b101;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_bus;
   int   total = 0;
   int   bad = 0;
   int   hi_cnt = 0;
   int   viol = 0;
   logic prev_oe = 1'b0;

   always #2 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_ram_target dut_i (
      .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .strap_i(strap),
      .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(Q);
         if (glitch && i == 3) begin
            sda_m = ~sda_m; tick(1); sda_m = ~sda_m; tick(Q - 1);
         end else begin
            tick(Q);
         end
         scl_m = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      ack = ~sda_bus; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(input bit master_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl_m = 1'b1; tick(Q);
         b[i] = sda_bus; tick(Q);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = ~master_ack; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic write_seq(input logic [7:0] ptr, input logic [7:0] d [], input string req);
      bit a;
      bus_start();
      send_byte(DEV_W, 1'b0, a); check(a, "R2", a, 1);
      send_byte(ptr, 1'b0, a);   check(a, req, a, 1);
      foreach (d[i]) begin
         send_byte(d[i], 1'b0, a); check(a, req, a, 1);
      end
      bus_stop();
   endtask

   task automatic read_at(input logic [7:0] ptr, input logic [7:0] exp [], input string req);
      bit a;
      logic [7:0] b;
      bus_start();
      send_byte(DEV_W, 1'b0, a); check(a, "R2", a, 1);
      send_byte(ptr, 1'b0, a);   check(a, "R3", a, 1);
      bus_start();
      send_byte(DEV_R, 1'b0, a); check(a, "R5", a, 1);
      foreach (exp[i]) begin
         recv_byte(i != exp.size() - 1, b);
         check(b == exp[i], req, b, exp[i]);
      end
      tick(Q);
      check(sda_oe == 1'b0, "R7", sda_oe, 0);
      bus_stop();
   endtask

   task automatic t_reset();
      check(sda_oe == 1'b0, "R1", sda_oe, 0);
   endtask

   task automatic t_write_then_read();
      write_seq(8'h10, '{8'h11, 8'h22, 8'h33, 8'h44}, "R3");
      read_at(8'h10, '{8'h11, 8'h22, 8'h33}, "R5");
   endtask

   task automatic t_direct_read();
      bit a;
      logic [7:0] b;
      bus_start();
      send_byte(DEV_R, 1'b0, a); check(a, "R6", a, 1);
      recv_byte(1'b0, b);
      check(b == 8'h44, "R6", b, 8'h44);
      bus_stop();
   endtask

   task automatic t_wrap();
      write_seq(8'hFE, '{8'hA1, 8'hA2, 8'hA3}, "R4");
      read_at(8'hFF, '{8'hA2, 8'hA3}, "R4");
   endtask

   task automatic t_mismatch();
      bit a;
      bus_start();
      send_byte(8'hA2, 1'b0, a); check(!a, "R2", a, 0);
      send_byte(8'h10, 1'b0, a); check(!a, "R2", a, 0);
      send_byte(8'h99, 1'b0, a); check(!a, "R2", a, 0);
      bus_stop();
      read_at(8'h10, '{8'h11}, "R2");
   endtask

   task automatic t_stop_mid();
      bit a;
      write_seq(8'h20, '{8'h55}, "R3");
      send_byte(8'h77, 1'b0, a); check(!a, "R8", a, 0);
      send_byte(8'h66, 1'b0, a); check(!a, "R8", a, 0);
      bus_stop();
      read_at(8'h20, '{8'h55}, "R8");
   endtask

   task automatic t_glitch();
      bit a;
      bus_start();
      send_byte(DEV_W, 1'b0, a); check(a, "R11", a, 1);
      send_byte(8'h30, 1'b0, a); check(a, "R11", a, 1);
      send_byte(8'hC3, 1'b1, a); check(a, "R11", a, 1);
      bus_stop();
      read_at(8'h30, '{8'hC3}, "R11");
   endtask

   task automatic t_sleep();
      bit a;
      logic [7:0] b;
      sleep = 1'b1; tick(4);
      bus_start();
      send_byte(DEV_W, 1'b0, a); check(!a, "R9", a, 0);
      check(sda_oe == 1'b0, "R9", sda_oe, 0);
      bus_stop();
      sleep = 1'b0; tick(4);
      bus_start();
      send_byte(DEV_R, 1'b0, a); check(a, "R9", a, 1);
      recv_byte(1'b0, b);
      check(b == 8'hA3, "R9", b, 8'hA3);
      bus_stop();
   endtask

   always @(negedge clk) begin
      if (scl_m) hi_cnt++;
      else       hi_cnt = 0;
      if (rst_n && sda_oe !== prev_oe && hi_cnt > 8) viol++;
      prev_oe = sda_oe;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(10);
      t_reset();
      t_write_then_read();
      t_direct_read();
      t_wrap();
      t_mismatch();
      t_stop_mid();
      t_glitch();
      t_sleep();
      check(viol == 0, "R10", viol, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule